// File: doc/BRIEF.md
# Pseudo-SRAM Device-Side Emulator

This block stands in for a byte-wide memory that sits behind an asynchronous, latched-address pseudo-SRAM pin interface. A host drives two chip selects (one active low, one active high), a write strobe, an output strobe, an address and data. The emulator samples all of these on a fast local clock, finds the edges that start an access, and captures the address and data at those edges. After that point the address and data pins have no further effect on the access. Reads are driven back on a split data bus (value plus drive enable) that the chip pad ring turns into a tristate pin.

Both access styles of such a part are supported. An access is controlled by the chip selects when the strobes are already set when the selects become active. It is controlled by a strobe when the part is already selected and the output or write strobe then falls. The storage is a parameterised array. The full part size corresponds to 17 address bits, and the default is smaller so that elaboration stays light.

A timing monitor measures how long each selected period lasts and how long the gap between periods lasts, both in clock cycles. It counts every period that is too short. Writes that land in such a faulty access are still stored, but they raise a separate sticky flag.

Top module: `psram_emu`

## Requirements
- R1: When the part is deselected (`ce_n_i` high or `ce_i` low), `dq_oe_o` stays low whatever the strobes do, and strobing `we_n_i` low stores nothing.
- R2: The address present when the part becomes selected is held for the whole access. Changing `addr_i` afterwards does not change the byte read.
- R3: If the part becomes selected with `we_n_i` high and `oe_n_i` low, the byte stored at the captured address is driven on `dq_out_o` with `dq_oe_o` high.
- R4: While selected with `we_n_i` high, a falling `oe_n_i` captures the address present at that edge, and that byte is driven.
- R5: While selected, a falling `we_n_i` captures the address and `dq_in_i` present at that edge and stores the byte. Later changes on those pins are ignored.
- R6: If the part becomes selected with `we_n_i` low and `oe_n_i` high, the `dq_in_i` value present at that edge is stored at the captured address.
- R7: `dq_oe_o` is low whenever `oe_n_i` has been high for the synchronizer depth plus one cycle, including during write accesses.
- R8: With a two-stage synchronizer, `dq_oe_o` goes high on the third rising clock after `oe_n_i` falls. It goes low on the second rising clock after `oe_n_i` rises.
- R9: A selected period shorter than `MIN_ACT_CYC` cycles (12, i.e. 120 ns at 100 MHz) raises `viol_o` and adds one to `viol_cnt_o`. A period of exactly `MIN_ACT_CYC` cycles does not.
- R10: A deselected gap shorter than `MIN_PRE_CYC` cycles (2) between two accesses is counted as a violation. A gap of exactly `MIN_PRE_CYC` cycles, and the first access after reset, are not.
- R11: A write in an access that violates R9 or R10 is still stored, and it sets the sticky `bad_wr_o`. A violating access without a write leaves `bad_wr_o` low.
- R12: `viol_o` stays high until reset. `viol_cnt_o` saturates at its all-ones value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n_i | input | 1 | Active-low chip select (asynchronous) |
| ce_i | input | 1 | Active-high chip select (asynchronous) |
| we_n_i | input | 1 | Active-low write strobe (asynchronous) |
| oe_n_i | input | 1 | Active-low output strobe (asynchronous) |
| addr_i | input | ADDR_W | Byte address |
| dq_in_i | input | DATA_W | Write data from the bus |
| dq_out_o | output | DATA_W | Read data, zero while not driving |
| dq_oe_o | output | 1 | Data bus drive enable |
| viol_o | output | 1 | Sticky timing-violation flag |
| viol_cnt_o | output | VIOL_CNT_W | Saturating violation count |
| bad_wr_o | output | 1 | Sticky flag: a write occurred in a violating access |

## Verification
The bench writes every address of a 16-byte configuration twice: once with strobe-controlled writes and once with select-controlled writes. It reads each address back in the opposite style. After each capture edge it moves the address and data pins, so a design that followed the pins instead of latching them would return the wrong byte. It also drives the strobes while only one of the two selects is active, and checks that nothing is driven or stored. The drive-enable latency is checked on the exact cycle in both directions, so an extra or missing register stage shows up. The violation limits are probed exactly at the threshold and one cycle below it, which catches off-by-one comparisons. Further short accesses push the counter past its maximum to show that it saturates instead of wrapping.

// File: rtl/psram_emu_pkg.sv
package psram_emu_pkg;

    // Control pins of the pseudo-SRAM interface, as sampled.
    typedef struct packed {
        logic ce_n;
        logic ce;
        logic we_n;
        logic oe_n;
    } pins_t;

    localparam pins_t PINS_IDLE = '{ce_n: 1'b1, ce: 1'b0, we_n: 1'b1, oe_n: 1'b1};

    // Both selects must be active for the part to be in an access.
    function automatic logic is_selected(pins_t p);
        return !p.ce_n && p.ce;
    endfunction

    // Access events found by the controller in one sampled cycle.
    typedef struct packed {
        logic sel;
        logic sel_rise;
        logic sel_fall;
        logic wr;
    } acc_evt_t;

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/psram_in_sync.sv
module psram_in_sync
    import psram_emu_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  pins_t             pins_raw,
    input  logic [ADDR_W-1:0] addr_raw,
    input  logic [DATA_W-1:0] data_raw,
    output pins_t             pins_s,
    output logic [ADDR_W-1:0] addr_s,
    output logic [DATA_W-1:0] data_s
);

    pins_t             pin_q [STAGES];
    logic [ADDR_W-1:0] adr_q [STAGES];
    logic [DATA_W-1:0] dat_q [STAGES];

    // Address and data go through the same number of stages as the
    // controls so that all three stay aligned at the capture edge.
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) begin
                    pin_q[g] <= PINS_IDLE;
                    adr_q[g] <= '0;
                    dat_q[g] <= '0;
                end else begin
                    pin_q[g] <= pins_raw;
                    adr_q[g] <= addr_raw;
                    dat_q[g] <= data_raw;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) begin
                    pin_q[g] <= PINS_IDLE;
                    adr_q[g] <= '0;
                    dat_q[g] <= '0;
                end else begin
                    pin_q[g] <= pin_q[g-1];
                    adr_q[g] <= adr_q[g-1];
                    dat_q[g] <= dat_q[g-1];
                end
            end
        end
    end

    assign pins_s = pin_q[STAGES-1];
    assign addr_s = adr_q[STAGES-1];
    assign data_s = dat_q[STAGES-1];

endmodule

// File: rtl/psram_access_ctl.sv
module psram_access_ctl
    import psram_emu_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  pins_t             pins_s,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [DATA_W-1:0] data_s,
    output acc_evt_t          evt,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              drive
);

    logic              sel, sel_q;
    logic              oe_n_q, we_n_q;
    logic              rd_q;
    logic [ADDR_W-1:0] lat_addr;
    logic              oe_fall, we_fall, ce_wr, latch;

    assign sel = is_selected(pins_s);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= 1'b0;
            oe_n_q <= 1'b1;
            we_n_q <= 1'b1;
        end else begin
            sel_q  <= sel;
            oe_n_q <= pins_s.oe_n;
            we_n_q <= pins_s.we_n;
        end
    end

    // Strobe edges count only inside an access that was already open.
    assign oe_fall = sel && sel_q && oe_n_q && !pins_s.oe_n && pins_s.we_n;
    assign we_fall = sel && sel_q && we_n_q && !pins_s.we_n;
    assign ce_wr   = sel && !sel_q && !pins_s.we_n && pins_s.oe_n;
    assign latch   = (sel && !sel_q) || oe_fall || we_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_addr <= '0;
        end else if (latch) begin
            lat_addr <= addr_s;
        end
    end

    // The storage reads the address that will be latched, so the byte
    // is ready in the same cycle as the latched address.
    assign rd_addr = latch ? addr_s : lat_addr;
    assign wr_addr = addr_s;
    assign wr_data = data_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= 1'b0;
        end else begin
            rd_q <= sel && !pins_s.oe_n && pins_s.we_n;
        end
    end

    // Turn-on waits one sampled cycle; turn-off follows the sampled pins.
    assign drive = rd_q && sel && !pins_s.oe_n && pins_s.we_n;

    assign evt.sel      = sel;
    assign evt.sel_rise = sel && !sel_q;
    assign evt.sel_fall = !sel && sel_q;
    assign evt.wr       = ce_wr || we_fall;

endmodule

// File: rtl/psram_store.sv
module psram_store #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else begin
            rd_data <= mem[rd_addr];
        end
    end

endmodule

// File: rtl/psram_timing_mon.sv
module psram_timing_mon
    import psram_emu_pkg::*;
#(
    parameter int MIN_ACT_CYC = 12,
    parameter int MIN_PRE_CYC = 2,
    parameter int VIOL_CNT_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  acc_evt_t              evt,
    output logic                  viol,
    output logic [VIOL_CNT_W-1:0] viol_cnt,
    output logic                  bad_wr
);

    localparam int LIM = max2(MIN_ACT_CYC, MIN_PRE_CYC);
    localparam int TW  = $clog2(LIM + 1);
    localparam logic [TW-1:0] ACT_LIM = TW'(MIN_ACT_CYC);
    localparam logic [TW-1:0] PRE_LIM = TW'(MIN_PRE_CYC);

    logic [TW-1:0] act_cnt, pre_cnt;
    logic          have_prev, acc_bad, acc_wr;
    logic          short_act, short_pre, viol_pulse;

    // Both counters stop at their limit: only "below limit" matters.
    always_ff @(posedge clk) begin
        if (rst) begin
            act_cnt   <= '0;
            pre_cnt   <= '0;
            have_prev <= 1'b0;
        end else begin
            if (evt.sel_rise) begin
                act_cnt <= TW'(1);
            end else if (evt.sel && act_cnt < ACT_LIM) begin
                act_cnt <= act_cnt + 1'b1;
            end
            if (evt.sel_fall) begin
                pre_cnt   <= TW'(1);
                have_prev <= 1'b1;
            end else if (!evt.sel && pre_cnt < PRE_LIM) begin
                pre_cnt <= pre_cnt + 1'b1;
            end
        end
    end

    assign short_act  = evt.sel_fall && (act_cnt < ACT_LIM);
    assign short_pre  = evt.sel_rise && have_prev && (pre_cnt < PRE_LIM);
    assign viol_pulse = short_act || short_pre;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_bad <= 1'b0;
            acc_wr  <= 1'b0;
        end else if (evt.sel_rise) begin
            acc_bad <= short_pre;
            acc_wr  <= evt.wr;
        end else if (evt.wr) begin
            acc_wr <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            viol     <= 1'b0;
            viol_cnt <= '0;
            bad_wr   <= 1'b0;
        end else begin
            if (viol_pulse) begin
                viol <= 1'b1;
                if (viol_cnt != '1) begin
                    viol_cnt <= viol_cnt + 1'b1;
                end
            end
            if (evt.sel_fall && acc_wr && (acc_bad || short_act)) begin
                bad_wr <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/psram_emu.sv
module psram_emu
    import psram_emu_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int MIN_ACT_CYC = 12,
    parameter int MIN_PRE_CYC = 2,
    parameter int VIOL_CNT_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ce_n_i,
    input  logic                  ce_i,
    input  logic                  we_n_i,
    input  logic                  oe_n_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [DATA_W-1:0]     dq_in_i,
    output logic [DATA_W-1:0]     dq_out_o,
    output logic                  dq_oe_o,
    output logic                  viol_o,
    output logic [VIOL_CNT_W-1:0] viol_cnt_o,
    output logic                  bad_wr_o
);

    pins_t             pins_raw, pins_s;
    logic [ADDR_W-1:0] addr_s, rd_addr, wr_addr;
    logic [DATA_W-1:0] data_s, wr_data, rd_data;
    acc_evt_t          evt;
    logic              drive;
    logic              sync_oe_n;

    assign pins_raw = '{ce_n: ce_n_i, ce: ce_i, we_n: we_n_i, oe_n: oe_n_i};

    psram_in_sync #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .pins_raw (pins_raw),
        .addr_raw (addr_i),
        .data_raw (dq_in_i),
        .pins_s   (pins_s),
        .addr_s   (addr_s),
        .data_s   (data_s)
    );

    psram_access_ctl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_ctl (
        .clk     (clk),
        .rst     (rst),
        .pins_s  (pins_s),
        .addr_s  (addr_s),
        .data_s  (data_s),
        .evt     (evt),
        .rd_addr (rd_addr),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .drive   (drive)
    );

    psram_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (evt.wr),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    psram_timing_mon #(
        .MIN_ACT_CYC (MIN_ACT_CYC),
        .MIN_PRE_CYC (MIN_PRE_CYC),
        .VIOL_CNT_W  (VIOL_CNT_W)
    ) u_mon (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .viol     (viol_o),
        .viol_cnt (viol_cnt_o),
        .bad_wr   (bad_wr_o)
    );

    assign sync_oe_n = pins_s.oe_n;
    assign dq_oe_o   = drive;
    assign dq_out_o  = drive ? rd_data : '0;

endmodule

// File: rtl/psram_emu_chk.sv
module psram_emu_chk #(
    parameter int VIOL_CNT_W = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  ce_n_i,
    input logic                  ce_i,
    input logic                  oe_n_i,
    input logic                  sync_oe_n,
    input logic                  dq_oe_o,
    input logic                  viol_o,
    input logic [VIOL_CNT_W-1:0] viol_cnt_o,
    input logic                  bad_wr_o
);

    // R1
    standby_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (ce_n_i && $past(ce_n_i) && $past(ce_n_i, 2)) |-> !dq_oe_o);

    // R1
    standby_low_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (!ce_i && !$past(ce_i) && !$past(ce_i, 2)) |-> !dq_oe_o);

    // R7
    oe_high_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (oe_n_i && $past(oe_n_i) && $past(oe_n_i, 2)) |-> !dq_oe_o);

    // R8
    drive_after_sample_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dq_oe_o) |-> (!$past(sync_oe_n) && !sync_oe_n));

    // R12
    viol_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $past(viol_o) |-> viol_o);

    // R12
    viol_cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (viol_cnt_o != $past(viol_cnt_o)) |->
            (VIOL_CNT_W'(viol_cnt_o - $past(viol_cnt_o)) == VIOL_CNT_W'(1)));

    // R9
    cnt_implies_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (viol_cnt_o != '0) |-> viol_o);

    // R11
    bad_wr_implies_viol_chk: assert property (@(posedge clk) disable iff (rst)
        bad_wr_o |-> viol_o);

endmodule

bind psram_emu psram_emu_chk #(.VIOL_CNT_W(VIOL_CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ce_n_i     (ce_n_i),
    .ce_i       (ce_i),
    .oe_n_i     (oe_n_i),
    .sync_oe_n  (sync_oe_n),
    .dq_oe_o    (dq_oe_o),
    .viol_o     (viol_o),
    .viol_cnt_o (viol_cnt_o),
    .bad_wr_o   (bad_wr_o)
);

// File: tb/psram_emu_test.sv
module psram_emu_test;

    localparam int AW  = 4;
    localparam int DW  = 8;
    localparam int CW  = 3;
    localparam int NA  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ce_n = 1'b1, ce = 1'b0, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          doe, viol, bad_wr;
    logic [CW-1:0] vcnt;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    psram_emu #(
        .ADDR_W      (AW),
        .DATA_W      (DW),
        .SYNC_STAGES (2),
        .MIN_ACT_CYC (12),
        .MIN_PRE_CYC (2),
        .VIOL_CNT_W  (CW)
    ) uut (
        .clk        (clk),
        .rst        (rst),
        .ce_n_i     (ce_n),
        .ce_i       (ce),
        .we_n_i     (we_n),
        .oe_n_i     (oe_n),
        .addr_i     (addr),
        .dq_in_i    (din),
        .dq_out_o   (dout),
        .dq_oe_o    (doe),
        .viol_o     (viol),
        .viol_cnt_o (vcnt),
        .bad_wr_o   (bad_wr)
    );

    function automatic logic [DW-1:0] pat(int a, int k);
        return DW'(a * 29 + k * 71 + 3);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic idle();
        ce_n = 1'b1; ce = 1'b0; we_n = 1'b1; oe_n = 1'b1;
    endtask

    // Strobe-controlled write; pins move after the falling strobe.
    task automatic wr_we(int a, logic [DW-1:0] d);
        ce_n = 1'b0; ce = 1'b1; we_n = 1'b1; oe_n = 1'b1; addr = AW'(a);
        tick(2);
        check("R7 no drive in write", 32'(doe), 0);
        we_n = 1'b0; din = d;
        tick(1);
        din = ~d; addr = AW'(a) ^ AW'(5);
        tick(11);
        idle();
        tick(3);
    endtask

    // Select-controlled write; pins move after the select edge.
    task automatic wr_ce(int a, logic [DW-1:0] d);
        we_n = 1'b0; oe_n = 1'b1; addr = AW'(a); din = d;
        ce_n = 1'b0; ce = 1'b1;
        tick(1);
        din = ~d; addr = AW'(a) ^ AW'(5);
        tick(13);
        idle();
        tick(3);
    endtask

    // Select-controlled read; address moves after the select edge.
    task automatic rd_ce(int a, logic [DW-1:0] exp, string req);
        we_n = 1'b1; oe_n = 1'b0; addr = AW'(a);
        ce_n = 1'b0; ce = 1'b1;
        tick(1);
        addr = AW'(a) ^ AW'(3);
        tick(5);
        check({req, " drive on"}, 32'(doe), 1);
        check({req, " data"}, 32'(dout), 32'(exp));
        tick(8);
        idle();
        tick(3);
    endtask

    // Strobe-controlled read with exact drive-enable timing (R8).
    task automatic rd_oe(int a, logic [DW-1:0] exp);
        ce_n = 1'b0; ce = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        addr = AW'(a) ^ AW'(7);
        tick(3);
        addr = AW'(a); oe_n = 1'b0;
        tick(1);
        addr = AW'(a) ^ AW'(7);
        tick(1);
        check("R8 off two clocks after oe fall", 32'(doe), 0);
        tick(1);
        check("R8 on three clocks after oe fall", 32'(doe), 1);
        check("R4 oe-edge address data", 32'(dout), 32'(exp));
        tick(6);
        oe_n = 1'b1;
        tick(1);
        check("R8 still on one clock after oe rise", 32'(doe), 1);
        tick(1);
        check("R8 R7 off two clocks after oe rise", 32'(doe), 0);
        tick(2);
        idle();
        tick(3);
    endtask

    // Generic access of a given length followed by a given gap.
    task automatic pulse(int act, int gap, logic w_n, logic o_n, int a, logic [DW-1:0] d);
        we_n = w_n; oe_n = o_n; addr = AW'(a); din = d;
        ce_n = 1'b0; ce = 1'b1;
        tick(act);
        idle();
        tick(gap);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        tick(3);
        rst = 1'b0;
        tick(2);
        check("reset drive", 32'(doe), 0);
        check("reset viol", 32'(viol), 0);
        check("reset viol count", 32'(vcnt), 0);
        check("reset bad write", 32'(bad_wr), 0);

        // R5 then R3/R2: strobe writes read back with select reads.
        for (int a = 0; a < NA; a++) wr_we(a, pat(a, 0));
        for (int a = 0; a < NA; a++) rd_ce(a, pat(a, 0), "R5 R3 R2");

        // R6 then R4/R8: select writes read back with strobe reads.
        for (int a = 0; a < NA; a++) wr_ce(a, pat(a, 1));
        for (int a = 0; a < NA; a++) rd_oe(a, pat(a, 1));

        // R1: deselected patterns drive nothing and store nothing.
        ce_n = 1'b1; ce = 1'b1; we_n = 1'b1; oe_n = 1'b0; addr = AW'(5);
        tick(4);
        check("R1 low select inactive", 32'(doe), 0);
        ce_n = 1'b0; ce = 1'b0;
        tick(4);
        check("R1 high select inactive", 32'(doe), 0);
        idle();
        tick(3);
        ce_n = 1'b1; ce = 1'b1; oe_n = 1'b1; addr = AW'(5); din = 8'hA5;
        tick(2);
        we_n = 1'b0;
        tick(6);
        we_n = 1'b1;
        tick(3);
        ce_n = 1'b0; ce = 1'b0; addr = AW'(6); din = 8'h3C;
        tick(2);
        we_n = 1'b0;
        tick(6);
        we_n = 1'b1;
        tick(2);
        idle();
        tick(3);
        rd_ce(5, pat(5, 1), "R1 standby write ignored a5");
        rd_ce(6, pat(6, 1), "R1 standby write ignored a6");
        check("R9 no violation in legal traffic", 32'(vcnt), 0);

        // R9/R10 thresholds: exact limits are legal.
        pulse(12, 2, 1'b1, 1'b1, 0, 8'h00);
        pulse(14, 3, 1'b1, 1'b1, 0, 8'h00);
        check("R9 R10 exact limits legal", 32'(vcnt), 0);
        check("R9 flag clear at limits", 32'(viol), 0);

        pulse(11, 3, 1'b1, 0, 1, 8'h00);
        check("R9 active one below limit", 32'(vcnt), 1);
        check("R9 flag set", 32'(viol), 1);

        pulse(14, 1, 1'b1, 1'b1, 0, 8'h00);
        pulse(14, 3, 1'b1, 0, 2, 8'h00);
        check("R10 gap one below limit", 32'(vcnt), 2);
        check("R11 no bad write without write", 32'(bad_wr), 0);

        // R11: short write still lands and is flagged.
        pulse(6, 3, 1'b0, 1'b1, 9, 8'h5C);
        check("R11 short write counted", 32'(vcnt), 3);
        check("R11 bad write flag", 32'(bad_wr), 1);
        rd_ce(9, 8'h5C, "R11 short write stored");

        // R12: sticky flag, count unchanged by legal traffic, saturation.
        check("R12 flag sticky", 32'(viol), 1);
        check("R12 count held", 32'(vcnt), 3);
        for (int i = 0; i < 6; i++) begin
            pulse(4, 3, 1'b1, 1'b1, 0, 8'h00);
            check("R12 saturating count", 32'(vcnt),
                  32'((3 + i + 1) > 7 ? 7 : (3 + i + 1)));
        end
        check("R12 flag still set", 32'(viol), 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule